// File: doc/BRIEF.md
# Serial Addressable Attenuator Control Receiver

This block is the device-side control port of a 7-bit step attenuator. It runs on the system clock and watches three slow serial pins: a serial clock, a serial data line and a latch enable. While the latch enable is low, each rising edge of the serial clock moves one data bit into a 16-bit frame register. The bit that enters first ends up in the lowest position.

When the latch enable rises, the block compares three bits of the received frame with a 3-bit strap value that is fixed on the board. If they agree, a new attenuation code is taken from the frame. If they differ, the current code is kept. Because of this compare, several attenuators can share one serial bus and each answers only to its own strap value. The output is a 7-bit code worth 0.25 dB per LSB, together with a one-cycle strobe for every write and a sticky flag that records an illegal top bit in the attenuation word.

All three serial pins pass through two-flop synchronisers before edge detection, so the system clock has to run at least four times faster than the serial clock.

Top module: `serial_atten_rx`

## Requirements
- R1: Bits are shifted in least significant bit first. One bit is taken on each serial clock rising edge seen while the synchronised latch enable is low.
- R2: Frame bits 7..0 hold the attenuation word and bits 15..8 hold the address word. Only frame bits 10..8 are compared with addrStrap[2..0]; frame bits 15..11 have no effect.
- R3: On a latch with an address mismatch, attenCode stays unchanged and updateStb stays low.
- R4: On a latch with an address match, attenCode takes frame bits 6..0, which equal the setting in dB times four (0 is the reference state, 127 is 31.75 dB). A latch enable level first sampled high at clock edge n shows on attenCode after edge n+2.
- R5: After reset, attenCode is 127, updateStb is 0 and frameErr is 0.
- R6: Shifting frame bits never changes attenCode; only a latch can change it.
- R7: updateStb is high for exactly one system clock cycle for each matching latch, including a latch that rewrites the same code.
- R8: A matching latch whose frame bit 7 is 1 sets frameErr, and frameErr stays set until reset. Bit 7 never reaches attenCode.
- R9: Serial clock edges while the latch enable is high do not shift. A second latch with no new bits reloads the same frame.
- R10: Frames are received correctly when each serial clock phase lasts two system clock cycles or longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock pin, asynchronous |
| serData | input | 1 | Serial data pin, asynchronous |
| latchEn | input | 1 | Latch enable pin, asynchronous |
| addrStrap | input | 3 | Static device address |
| attenCode | output | 7 | Attenuation state, 0.25 dB per LSB |
| updateStb | output | 1 | One-cycle pulse on each state write |
| frameErr | output | 1 | Sticky flag: a frame latched with bit 7 set |

## Verification
The hardest case to reach from the ports is the one where serial clock edges arrive while the latch enable is still high. These edges must leave the frame register unchanged, and that register can only be seen through a later latch. The stimulus therefore keeps the latch enable high, clocks in a burst of ones, then pulses the latch enable again with no new frame and expects the previous code to be rewritten together with a strobe. The same cycle-accurate reference model also covers mismatching addresses, junk in the upper address bits, and a set bit 7 followed by a clean frame, which shows that the error flag is sticky.

// File: rtl/serial_atten_pkg.sv
package serial_atten_pkg;
  typedef struct packed {
    logic shiftEv;
    logic latchEv;
    logic shiftBit;
  } ctrlStb_t;
endpackage

// File: rtl/serial_atten_ctrl.sv
module serial_atten_ctrl
  import serial_atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     serClk,
  input  logic     serData,
  input  logic     latchEn,
  output ctrlStb_t ctrlStb
);
  localparam int LANES = 3;
  localparam int PIPE  = SYNC_STAGES + 1;
  localparam int LN_CLK = 0;
  localparam int LN_DAT = 1;
  localparam int LN_LE  = 2;
  // Clock and latch lanes reset high, so a pin that is already high at reset gives no false edge
  localparam logic [LANES-1:0] RST_VAL = 3'b101;

  logic [LANES-1:0] pinVec;
  logic [PIPE-1:0]  pipe [LANES];

  assign pinVec = {latchEn, serData, serClk};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= {PIPE{RST_VAL[g]}};
      else        pipe[g] <= {pipe[g][PIPE-2:0], pinVec[g]};
    end
  end

  logic clkNow, clkOld, leNow, leOld;
  assign clkNow = pipe[LN_CLK][SYNC_STAGES-1];
  assign clkOld = pipe[LN_CLK][SYNC_STAGES];
  assign leNow  = pipe[LN_LE][SYNC_STAGES-1];
  assign leOld  = pipe[LN_LE][SYNC_STAGES];

  always_comb begin
    ctrlStb.shiftEv  = clkNow & ~clkOld & ~leNow;
    ctrlStb.latchEv  = leNow & ~leOld;
    ctrlStb.shiftBit = pipe[LN_DAT][SYNC_STAGES-1];
  end

  AST_LATCH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStb.latchEv |=> !ctrlStb.latchEv); // R4
endmodule

// File: rtl/serial_atten_dp.sv
module serial_atten_dp
  import serial_atten_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int WORD_W  = 8,
  parameter int CODE_W  = 7,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStb_t          ctrlStb,
  input  logic [ADDR_W-1:0] addrStrap,
  output logic [CODE_W-1:0] attenCode,
  output logic              updateStb,
  output logic              frameErr
);
  localparam int ADDR_LSB = WORD_W;
  localparam int FLAG_BIT = WORD_W - 1;
  localparam logic [CODE_W-1:0] RESET_CODE = {CODE_W{1'b1}};

  logic [FRAME_W-1:0] frameReg;
  logic [ADDR_W-1:0]  addrField;
  logic               addrHit;
  logic               writeEn;

  assign addrField = frameReg[ADDR_LSB +: ADDR_W];
  assign addrHit   = (addrField == addrStrap);
  assign writeEn   = ctrlStb.latchEv & addrHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frameReg <= '0;
    else if (ctrlStb.shiftEv) frameReg <= {ctrlStb.shiftBit, frameReg[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attenCode <= RESET_CODE;
      updateStb <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      updateStb <= writeEn;
      if (writeEn) begin
        attenCode <= frameReg[CODE_W-1:0];
        frameErr  <= frameErr | frameReg[FLAG_BIT];
      end
    end
  end

  AST_HOLD_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlStb.latchEv |=> $stable(attenCode)); // R6
  AST_MISMATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStb.latchEv && !addrHit) |=> ($stable(attenCode) && !updateStb)); // R3
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    updateStb |=> !updateStb); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |=> frameErr); // R8
endmodule

// File: rtl/serial_atten_rx.sv
module serial_atten_rx
  import serial_atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8,
  parameter int CODE_W      = 7,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  logic              latchEn,
  input  logic [ADDR_W-1:0] addrStrap,
  output logic [CODE_W-1:0] attenCode,
  output logic              updateStb,
  output logic              frameErr
);
  localparam int FRAME_W = 2 * WORD_W;

  ctrlStb_t ctrlStb;

  serial_atten_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .latchEn(latchEn), .ctrlStb(ctrlStb)
  );

  serial_atten_dp #(.FRAME_W(FRAME_W), .WORD_W(WORD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrlStb(ctrlStb), .addrStrap(addrStrap),
    .attenCode(attenCode), .updateStb(updateStb), .frameErr(frameErr)
  );
endmodule

// File: tb/serial_atten_rx_bench.sv
module serial_atten_rx_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic pClk = 0, pData = 0, pLe = 0;
  logic [2:0] strap = 3'd3;
  logic [6:0] attenCode;
  logic updateStb, frameErr;

  int checks = 0, errors = 0, cyc = 0, stbCount = 0;

  always #10 clk = ~clk;

  serial_atten_rx u_serial_atten_rx (
    .clk(clk), .rst_n(rst_n), .serClk(pClk), .serData(pData), .latchEn(pLe),
    .addrStrap(strap), .attenCode(attenCode), .updateStb(updateStb), .frameErr(frameErr)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: pins pass two sampling stages, edges compare against one more
  int c1, c2, c3, l1, l2, l3, d1, d2;
  int mFrame, mCode, mStb, mErr;
  always @(posedge clk) begin
    if (!rst_n) begin
      c1 = 1; c2 = 1; c3 = 1; l1 = 1; l2 = 1; l3 = 1; d1 = 0; d2 = 0;
      mFrame = 0; mCode = 127; mStb = 0; mErr = 0;
    end else begin
      mStb = 0;
      if (c2 == 1 && c3 == 0 && l2 == 0) mFrame = (mFrame >> 1) | (d2 << 15);
      if (l2 == 1 && l3 == 0 && ((mFrame >> 8) & 7) == int'(strap)) begin
        mCode = mFrame % 128;
        mStb = 1;
        if (((mFrame >> 7) & 1) == 1) mErr = 1;
      end
      c3 = c2; c2 = c1; c1 = int'(pClk);
      l3 = l2; l2 = l1; l1 = int'(pLe);
      d2 = d1; d1 = int'(pData);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 code per cycle", int'(attenCode), mCode);
      chk("R7 strobe per cycle", int'(updateStb), mStb);
      chk("R8 flag per cycle", int'(frameErr), mErr);
      if (updateStb) stbCount++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b, int half);
    pData = b; tick(half);
    pClk = 1;  tick(half);
    pClk = 0;
  endtask

  task automatic sendFrame(logic [7:0] att, logic [7:0] adr, int half);
    for (int i = 0; i < 8; i++) sendBit(att[i], half);
    for (int i = 0; i < 8; i++) sendBit(adr[i], half);
    tick(4);
  endtask

  task automatic pulseLe(int width);
    stbCount = 0;
    pLe = 1; tick(width);
    pLe = 0; tick(5);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R5 reset code", int'(attenCode), 127);
    chk("R5 reset strobe", int'(updateStb), 0);
    chk("R5 reset flag", int'(frameErr), 0);
    rst_n = 1; tick(3);
    chk("R5 code after release", int'(attenCode), 127);

    sendFrame(8'd73, 8'h03, 2);
    chk("R6 code held after shifting", int'(attenCode), 127);
    pulseLe(3);
    chk("R4 18.25 dB loaded", int'(attenCode), 73);
    chk("R7 one strobe", stbCount, 1);

    sendFrame(8'd20, 8'h05, 3);
    pulseLe(3);
    chk("R3 mismatch keeps code", int'(attenCode), 73);
    chk("R3 mismatch no strobe", stbCount, 0);

    sendFrame(8'd0, 8'hFB, 2);
    pulseLe(2);
    chk("R2 upper address bits ignored", int'(attenCode), 0);

    pLe = 1; tick(3);
    for (int k = 0; k < 5; k++) sendBit(1'b1, 2);
    pLe = 0; tick(4);
    pulseLe(3);
    chk("R9 no shift with latch high", int'(attenCode), 0);
    chk("R7 rewrite strobes", stbCount, 1);

    sendFrame(8'h7F, 8'h03, 2);
    pulseLe(3);
    chk("R4 maximum code", int'(attenCode), 127);

    sendFrame(8'h01, 8'h03, 2);
    pulseLe(3);
    chk("R1 first bit is LSB", int'(attenCode), 1);

    sendFrame(8'h85, 8'h03, 2);
    pulseLe(3);
    chk("R8 bit7 excluded", int'(attenCode), 5);
    chk("R8 flag set", int'(frameErr), 1);

    sendFrame(8'h10, 8'h03, 4);
    pulseLe(3);
    chk("R8 flag sticky", int'(frameErr), 1);
    chk("R10 slow clock frame", int'(attenCode), 16);

    strap = 3'd6; tick(2);
    sendFrame(8'h22, 8'h06, 2);
    pulseLe(3);
    chk("R2 new strap match", int'(attenCode), 34);
    chk("R10 two-cycle phases", stbCount, 1);

    sendFrame(8'h40, 8'h03, 2);
    pulseLe(3);
    chk("R3 old address rejected", int'(attenCode), 34);

    tick(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule